// File: doc/BRIEF.md
# Multi-Channel Configurable CRC Engine

This block computes cyclic redundancy checks for eight independent channels behind one 32-bit register bus. Each channel keeps its own settings and its own running CRC value. Software either selects one of fifteen standard algorithms by writing a catalogue code, or programs the generator polynomial, start value, final XOR mask, width (1 to 32 bits) and the three ordering options directly. It then streams 32-bit data words into the channel and reads the finished checksum from the result register.

Each data word is absorbed in the clock cycle of its write: four byte updates are chained in one combinational step, so back-to-back writes on consecutive cycles are accepted. The running value is held left-aligned in a 32-bit register so that one update datapath serves every width. Reads are combinational from the address and return register contents or the formatted result in the same cycle.

Top module: `crc_hub`

## Requirements
- R1: The channel is selected by address bits [8:6] (a 0x40-byte window per channel). Within a window the word offsets are: 0x00 catalogue code, 0x04 clear, 0x08 polynomial, 0x0C start value, 0x10 final XOR, 0x14 option word, 0x18 data, 0x1C result. Offsets 0x20 to 0x3F read as zero and writes to them change nothing. After reset every register of every channel reads zero.
- R2: Writing a code from 1 to 15 to the catalogue register stores the code and loads the channel's polynomial, start value, final XOR, width and both reflection flags with that algorithm's standard parameters (byte reversal cleared), and loads the running value with the start value. Codes 1 to 15 are, in order: CRC-32, CRC-32 AUTOSAR, CRC-16 CCITT (reflected, start 0), CRC-16 XMODEM, CRC-16 MODBUS, CRC-16 DNP, CRC-16 X.25, CRC-16 USB, CRC-16 MAXIM, CRC-16 IBM, CRC-8 MAXIM, CRC-8 ROHC, CRC-8 ITU, CRC-8, CRC-5 USB.
- R3: Writing code 0 or any code above 15 stores the code but leaves every other setting and the running value unchanged.
- R4: Writing a word with bit 0 set to the clear register returns all settings, the stored code and the running value of that channel to zero; writing it with bit 0 clear changes nothing. The clear register always reads zero.
- R5: The option word holds the width in bits [5:0], input bit reflection in bit 8, output reflection in bit 16 and input byte reversal in bit 24, and reads back with all other bits zero. A width of 0 or above 32 behaves as 32.
- R6: Writing the start value register loads the running value with it (low width bits only), using the width configured at that moment.
- R7: Each data write feeds its four bytes, least significant byte first, or most significant first when byte reversal is set; with input reflection each byte is bit-reversed before entering the MSB-first update. A write is absorbed in its clock cycle, so writes on consecutive cycles are all taken.
- R8: The result reads as the running value, reversed over its low width bits when output reflection is set, then XORed with the final XOR value, masked to the width and zero-extended to 32 bits.
- R9: Writes to the result register have no effect.
- R10: A write to one channel never changes another channel's settings, running value or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 7 | Word address, byte address bits [8:2], used for both read and write |
| wr_en_i | input | 1 | Write strobe, one register write per asserted cycle |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i, combinational |

## Verification
Every register write takes effect at the clock edge on which it is strobed, and the read path is combinational, so any value written or computed is visible on rd_data_o in the cycle right after that edge. The bench drives address and data at the falling edge, lets the write land on the following rising edge, and samples reads one nanosecond after a later falling edge, so no check depends on same-edge ordering. Bursts of data writes on consecutive cycles to alternating channels are followed by the result reads only after the last write edge, and the expected checksum comes from a bit-serial reference in the bench that is itself checked against the published check values over the string "123456789".

// File: rtl/crc_hub_pkg.sv
// Shared types and helpers for the multi-channel CRC engine.
// Assumes a 32-bit data path and a CRC width of at most 32 bits.
package crc_hub_pkg;

    localparam int CRC_MAX_W = 32;
    localparam int BYTE_W    = 8;

    // Word index of each register inside a channel window; 8..15 are reserved.
    typedef enum logic [3:0] {
        IDX_CODE   = 4'd0,
        IDX_CLEAR  = 4'd1,
        IDX_POLY   = 4'd2,
        IDX_START  = 4'd3,
        IDX_FINAL  = 4'd4,
        IDX_OPTS   = 4'd5,
        IDX_DATA   = 4'd6,
        IDX_RESULT = 4'd7
    } reg_idx_e;

    // Complete algorithm description of one channel.
    typedef struct packed {
        logic [CRC_MAX_W-1:0] poly;
        logic [CRC_MAX_W-1:0] start;
        logic [CRC_MAX_W-1:0] fin_xor;
        logic [5:0]           width;
        logic                 refl_in;
        logic                 refl_out;
        logic                 swap_bytes;
    } chan_cfg_t;

    function automatic chan_cfg_t make_cfg(input logic [31:0] poly,
                                           input logic [31:0] start,
                                           input logic [31:0] fin_xor,
                                           input logic [5:0]  width,
                                           input logic        refl);
        chan_cfg_t c;
        c.poly       = poly;
        c.start      = start;
        c.fin_xor    = fin_xor;
        c.width      = width;
        c.refl_in    = refl;
        c.refl_out   = refl;
        c.swap_bytes = 1'b0;
        return c;
    endfunction

    function automatic logic [7:0] flip8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    function automatic logic [31:0] flip32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    // Left-alignment shift for a width field; 0 and >32 behave as 32.
    function automatic logic [5:0] align_shift(input logic [5:0] w);
        if (w == 6'd0 || w > 6'd32) return 6'd0;
        return 6'(CRC_MAX_W - int'(w));
    endfunction

endpackage

// File: rtl/crc_hub_catalog.sv
// Catalogue decoder: maps an 8-bit algorithm code to its standard parameters.
// Assumes codes 1..15 are defined; any other code reports no hit.
module crc_hub_catalog
    import crc_hub_pkg::*;
(
    input  logic [7:0] code_i,
    output chan_cfg_t  cfg_o,
    output logic       hit_o
);

    // Combinational table lookup of the fifteen standard algorithms.
    always_comb begin
        hit_o = 1'b1;
        cfg_o = '0;
        case (code_i)
            8'd1:  cfg_o = make_cfg(32'h04C1_1DB7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd32, 1'b1);
            8'd2:  cfg_o = make_cfg(32'hF4AC_FB13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd32, 1'b1);
            8'd3:  cfg_o = make_cfg(32'h0000_1021, 32'h0000_0000, 32'h0000_0000, 6'd16, 1'b1);
            8'd4:  cfg_o = make_cfg(32'h0000_1021, 32'h0000_0000, 32'h0000_0000, 6'd16, 1'b0);
            8'd5:  cfg_o = make_cfg(32'h0000_8005, 32'h0000_FFFF, 32'h0000_0000, 6'd16, 1'b1);
            8'd6:  cfg_o = make_cfg(32'h0000_3D65, 32'h0000_0000, 32'h0000_FFFF, 6'd16, 1'b1);
            8'd7:  cfg_o = make_cfg(32'h0000_1021, 32'h0000_FFFF, 32'h0000_FFFF, 6'd16, 1'b1);
            8'd8:  cfg_o = make_cfg(32'h0000_8005, 32'h0000_FFFF, 32'h0000_FFFF, 6'd16, 1'b1);
            8'd9:  cfg_o = make_cfg(32'h0000_8005, 32'h0000_0000, 32'h0000_FFFF, 6'd16, 1'b1);
            8'd10: cfg_o = make_cfg(32'h0000_8005, 32'h0000_0000, 32'h0000_0000, 6'd16, 1'b1);
            8'd11: cfg_o = make_cfg(32'h0000_0031, 32'h0000_0000, 32'h0000_0000, 6'd8,  1'b1);
            8'd12: cfg_o = make_cfg(32'h0000_0007, 32'h0000_00FF, 32'h0000_0000, 6'd8,  1'b1);
            8'd13: cfg_o = make_cfg(32'h0000_0007, 32'h0000_0000, 32'h0000_0055, 6'd8,  1'b0);
            8'd14: cfg_o = make_cfg(32'h0000_0007, 32'h0000_0000, 32'h0000_0000, 6'd8,  1'b0);
            8'd15: cfg_o = make_cfg(32'h0000_0005, 32'h0000_001F, 32'h0000_001F, 6'd5,  1'b1);
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/crc_hub_byte_step.sv
// One byte of MSB-first CRC update on a left-aligned state.
// Assumes the polynomial is already shifted to the top of the word and that
// bits below the CRC width are zero in both state and polynomial.
module crc_hub_byte_step #(
    parameter int STATE_W = 32
) (
    input  logic [STATE_W-1:0] state_i,
    input  logic [STATE_W-1:0] poly_i,
    input  logic [7:0]         byte_i,
    output logic [STATE_W-1:0] state_o
);

    // Eight shift/XOR stages after injecting the byte at the top.
    always_comb begin
        logic [STATE_W-1:0] s;
        s = state_i ^ {byte_i, {(STATE_W-8){1'b0}}};
        for (int i = 0; i < 8; i++) begin
            s = s[STATE_W-1] ? ((s << 1) ^ poly_i) : (s << 1);
        end
        state_o = s;
    end

endmodule

// File: rtl/crc_hub_chan.sv
// One CRC channel: settings registers, running state, 4-byte update chain
// and result formatting. Assumes the parent gates wr_en_i by channel select
// and that reads are combinational from rd_idx_i.
module crc_hub_chan
    import crc_hub_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int LANES = DATA_W / BYTE_W;

    logic [7:0]          code_q;
    chan_cfg_t           cfg_q;
    logic [DATA_W-1:0]   state_q;

    chan_cfg_t           cat_cfg;
    logic                cat_hit;
    logic [5:0]          sh;
    logic [DATA_W-1:0]   poly_al;
    logic [DATA_W-1:0]   chain [0:LANES];
    logic [DATA_W-1:0]   out_raw;
    logic [DATA_W-1:0]   out_mask;
    logic [DATA_W-1:0]   result;

    logic wr_code, wr_clear, wr_poly, wr_start, wr_final, wr_opts, wr_data, wr_result;

    crc_hub_catalog u_catalog (
        .code_i (wr_data_i[7:0]),
        .cfg_o  (cat_cfg),
        .hit_o  (cat_hit)
    );

    // Decode the register targeted by this cycle's write.
    always_comb begin
        wr_code   = wr_en_i && (wr_idx_i == IDX_W'(IDX_CODE));
        wr_clear  = wr_en_i && (wr_idx_i == IDX_W'(IDX_CLEAR)) && wr_data_i[0];
        wr_poly   = wr_en_i && (wr_idx_i == IDX_W'(IDX_POLY));
        wr_start  = wr_en_i && (wr_idx_i == IDX_W'(IDX_START));
        wr_final  = wr_en_i && (wr_idx_i == IDX_W'(IDX_FINAL));
        wr_opts   = wr_en_i && (wr_idx_i == IDX_W'(IDX_OPTS));
        wr_data   = wr_en_i && (wr_idx_i == IDX_W'(IDX_DATA));
        wr_result = wr_en_i && (wr_idx_i == IDX_W'(IDX_RESULT));
    end

    // Alignment of the configured width and the left-aligned polynomial.
    always_comb begin
        sh      = align_shift(cfg_q.width);
        poly_al = cfg_q.poly << sh;
    end

    assign chain[0] = state_q;

    // Byte lanes of one data word, chained in feed order.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [7:0] raw;
        logic [7:0] fed;
        assign raw = cfg_q.swap_bytes ? wr_data_i[BYTE_W*(LANES-1-k) +: BYTE_W]
                                      : wr_data_i[BYTE_W*k +: BYTE_W];
        assign fed = cfg_q.refl_in ? flip8(raw) : raw;
        crc_hub_byte_step #(.STATE_W(DATA_W)) u_step (
            .state_i (chain[k]),
            .poly_i  (poly_al),
            .byte_i  (fed),
            .state_o (chain[k+1])
        );
    end

    // Settings and running-state registers.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_clear) begin
            code_q  <= '0;
            cfg_q   <= '0;
            state_q <= '0;
        end else if (wr_code) begin
            code_q <= wr_data_i[7:0];
            if (cat_hit) begin
                cfg_q   <= cat_cfg;
                state_q <= cat_cfg.start << align_shift(cat_cfg.width);
            end
        end else if (wr_poly) begin
            cfg_q.poly <= wr_data_i;
        end else if (wr_start) begin
            cfg_q.start <= wr_data_i;
            state_q     <= wr_data_i << sh;
        end else if (wr_final) begin
            cfg_q.fin_xor <= wr_data_i;
        end else if (wr_opts) begin
            cfg_q.width      <= wr_data_i[5:0];
            cfg_q.refl_in    <= wr_data_i[8];
            cfg_q.refl_out   <= wr_data_i[16];
            cfg_q.swap_bytes <= wr_data_i[24];
        end else if (wr_data) begin
            state_q <= chain[LANES];
        end
    end

    // Format the result: align or reflect, apply final XOR, mask to width.
    always_comb begin
        out_raw  = cfg_q.refl_out ? flip32(state_q) : (state_q >> sh);
        out_mask = {DATA_W{1'b1}} >> sh;
        result   = (out_raw ^ cfg_q.fin_xor) & out_mask;
    end

    // Read mux over the channel's registers; reserved words read zero.
    always_comb begin
        case (rd_idx_i)
            IDX_W'(IDX_CODE):   rd_data_o = {24'd0, code_q};
            IDX_W'(IDX_POLY):   rd_data_o = cfg_q.poly;
            IDX_W'(IDX_START):  rd_data_o = cfg_q.start;
            IDX_W'(IDX_FINAL):  rd_data_o = cfg_q.fin_xor;
            IDX_W'(IDX_OPTS):   rd_data_o = {7'd0, cfg_q.swap_bytes, 7'd0, cfg_q.refl_out,
                                             7'd0, cfg_q.refl_in, 2'd0, cfg_q.width};
            IDX_W'(IDX_RESULT): rd_data_o = result;
            default:            rd_data_o = '0;
        endcase
    end

    // R4: a clear leaves every setting and the state at zero.
    a_r4_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clear |=> (state_q == '0 && cfg_q == '0 && code_q == '0));

    // R9: a result write changes neither the state nor the settings.
    a_r9_result_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        wr_result |=> ($stable(state_q) && $stable(cfg_q)));

    // R10: a cycle with no write to this channel holds everything.
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(state_q) && $stable(cfg_q) && $stable(code_q)));

    // R3: an unknown code keeps the algorithm and the running value.
    a_r3_unknown_code_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_code && !cat_hit) |=> ($stable(cfg_q) && $stable(state_q)));

    // R8: no result bit above the effective width is ever set.
    a_r8_result_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (sh != 6'd0) |-> ((result >> (DATA_W - int'(sh))) == '0));

endmodule

// File: rtl/crc_hub.sv
// Top of the multi-channel CRC engine: address decode over NUM_CH windows,
// one crc_hub_chan per window, and the read mux. Assumes word-aligned
// accesses; the address port carries byte-address bits above bit 1.
module crc_hub #(
    parameter int NUM_CH    = 8,
    parameter int WIN_BYTES = 64,
    parameter int DATA_W    = 32
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [$clog2(NUM_CH*WIN_BYTES)-1:2]       addr_i,
    input  logic                                      wr_en_i,
    input  logic [DATA_W-1:0]                         wr_data_i,
    output logic [DATA_W-1:0]                         rd_data_o
);

    localparam int ADDR_W = $clog2(NUM_CH * WIN_BYTES);
    localparam int WIN_W  = $clog2(WIN_BYTES);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int IDX_W  = WIN_W - 2;

    logic [CH_W-1:0]   ch_sel;
    logic [IDX_W-1:0]  word_idx;
    logic [DATA_W-1:0] ch_rd [NUM_CH];

    // Split the address into channel number and word offset.
    always_comb begin
        ch_sel   = addr_i[ADDR_W-1:WIN_W];
        word_idx = addr_i[WIN_W-1:2];
    end

    // One channel instance per address window.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic sel_wr;
        assign sel_wr = wr_en_i && (ch_sel == CH_W'(g));
        crc_hub_chan #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (sel_wr),
            .wr_idx_i  (word_idx),
            .wr_data_i (wr_data_i),
            .rd_idx_i  (word_idx),
            .rd_data_o (ch_rd[g])
        );
    end

    // Return the addressed channel's read data.
    assign rd_data_o = ch_rd[ch_sel];

    // R1: the reserved upper half of each window reads zero.
    a_r1_reserved_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx >= IDX_W'(8)) |-> (rd_data_o == '0));

endmodule

// File: tb/crc_hub_tb_top.sv
`timescale 1ns/1ps
module crc_hub_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:2]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam int O_CODE = 'h00, O_CLR = 'h04, O_POLY = 'h08, O_START = 'h0C,
                   O_FIN = 'h10, O_OPT = 'h14, O_DATA = 'h18, O_RES = 'h1C;

    always #4 clk = ~clk;

    crc_hub dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr),
        .wr_en_i   (we),
        .wr_data_i (wdata),
        .rd_data_o (rdata)
    );

    function automatic logic [6:0] wa(int ch, int off);
        return 7'((ch * 64 + off) >> 2);
    endfunction

    task automatic wr(int ch, int off, logic [31:0] d);
        @(negedge clk);
        addr = wa(ch, off); we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(int ch, int off, output logic [31:0] d);
        @(negedge clk);
        addr = wa(ch, off);
        #1 d = rdata;
    endtask

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, got, exp);
        end
    endtask

    task automatic rd_check(string req, string what, int ch, int off, logic [31:0] exp);
        logic [31:0] v;
        rd(ch, off, v);
        check(req, what, v, exp);
    endtask

    // Bit-serial reference over the unaligned register, true width.
    function automatic logic [31:0] ref_crc(logic [31:0] poly, logic [31:0] init,
                                            logic [31:0] xo, int w, bit ri, bit ro,
                                            logic [7:0] msg [0:15], int n);
        logic [31:0] mask, crc, r;
        logic [7:0] b;
        bit fb;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
        crc = init & mask;
        for (int i = 0; i < n; i++) begin
            b = msg[i];
            if (ri) for (int j = 0; j < 8; j++) b[j] = msg[i][7-j];
            for (int j = 7; j >= 0; j--) begin
                fb = crc[w-1] ^ b[j];
                crc = (crc << 1) & mask;
                if (fb) crc = crc ^ (poly & mask);
            end
        end
        if (ro) begin
            r = '0;
            for (int k = 0; k < w; k++) if (crc[k]) r[w-1-k] = 1'b1;
            crc = r;
        end
        return (crc ^ xo) & mask;
    endfunction

    // Standard parameters and published check values, per catalogue code.
    task automatic cat(int code, output logic [31:0] p, output logic [31:0] i,
                       output logic [31:0] x, output int w, output bit rf,
                       output logic [31:0] chk);
        case (code)
            1:  begin p='h04C11DB7; i='hFFFFFFFF; x='hFFFFFFFF; w=32; rf=1; chk='hCBF43926; end
            2:  begin p='hF4ACFB13; i='hFFFFFFFF; x='hFFFFFFFF; w=32; rf=1; chk='h1697D06A; end
            3:  begin p='h1021; i='h0;    x='h0;    w=16; rf=1; chk='h2189; end
            4:  begin p='h1021; i='h0;    x='h0;    w=16; rf=0; chk='h31C3; end
            5:  begin p='h8005; i='hFFFF; x='h0;    w=16; rf=1; chk='h4B37; end
            6:  begin p='h3D65; i='h0;    x='hFFFF; w=16; rf=1; chk='hEA82; end
            7:  begin p='h1021; i='hFFFF; x='hFFFF; w=16; rf=1; chk='h906E; end
            8:  begin p='h8005; i='hFFFF; x='hFFFF; w=16; rf=1; chk='hB4C8; end
            9:  begin p='h8005; i='h0;    x='hFFFF; w=16; rf=1; chk='h44C2; end
            10: begin p='h8005; i='h0;    x='h0;    w=16; rf=1; chk='hBB3D; end
            11: begin p='h31;   i='h0;    x='h0;    w=8;  rf=1; chk='hA1; end
            12: begin p='h07;   i='hFF;   x='h0;    w=8;  rf=1; chk='hD0; end
            13: begin p='h07;   i='h0;    x='h55;   w=8;  rf=0; chk='hA1; end
            14: begin p='h07;   i='h0;    x='h0;    w=8;  rf=0; chk='hF4; end
            default: begin p='h05; i='h1F; x='h1F; w=5; rf=1; chk='h19; end
        endcase
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0]  msg [0:15];
        logic [7:0]  m2 [0:15];
        logic [31:0] p, i, x, chk, v, v2, words [0:3];
        int w, n;
        bit rf;

        void'($urandom(32'h5EED_C0DE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state reads zero.
        rd_check("R1", "reset code", 0, O_CODE, 32'h0);
        rd_check("R1", "reset result", 7, O_RES, 32'h0);
        rd_check("R1", "reset options", 3, O_OPT, 32'h0);

        // R2, R7: each catalogue entry, reference vs published value and DUT over "12345678".
        for (int k = 0; k < 9; k++) msg[k] = 8'h31 + 8'(k);
        for (int code = 1; code <= 15; code++) begin
            int ch = code % 8;
            cat(code, p, i, x, w, rf, chk);
            check("R2", $sformatf("reference check code %0d", code),
                  ref_crc(p, i, x, w, rf, rf, msg, 9), chk);
            wr(ch, O_CODE, 32'(code));
            wr(ch, O_DATA, 32'h3433_3231);
            wr(ch, O_DATA, 32'h3837_3635);
            rd_check("R2", $sformatf("catalogue result code %0d", code), ch, O_RES,
                     ref_crc(p, i, x, w, rf, rf, msg, 8));
        end
        // R2, R5: CRC-32 settings readback.
        wr(1, O_CODE, 32'd1);
        rd_check("R2", "poly after code 1", 1, O_POLY, 32'h04C1_1DB7);
        rd_check("R2", "start after code 1", 1, O_START, 32'hFFFF_FFFF);
        rd_check("R2", "final after code 1", 1, O_FIN, 32'hFFFF_FFFF);
        rd_check("R5", "options after code 1", 1, O_OPT, 32'h0001_0120);
        rd_check("R2", "code readback", 1, O_CODE, 32'd1);

        // R3: code 0 and code 0x40 store the code only.
        wr(1, O_DATA, 32'h1234_5678);
        rd(1, O_RES, v);
        wr(1, O_CODE, 32'h40);
        rd_check("R3", "code 0x40 stored", 1, O_CODE, 32'h40);
        rd_check("R3", "poly kept after 0x40", 1, O_POLY, 32'h04C1_1DB7);
        rd_check("R3", "result kept after 0x40", 1, O_RES, v);
        wr(1, O_CODE, 32'h0);
        rd_check("R3", "result kept after 0", 1, O_RES, v);

        // R5, R6, R7, R8: random hand-set algorithms.
        for (int it = 0; it < 48; it++) begin
            int ch = int'($urandom % 8);
            bit ri = $urandom[0], ro = $urandom[0], br = $urandom[0];
            logic [31:0] opt;
            w = 1 + int'($urandom % 32);
            p = $urandom; i = $urandom; x = $urandom;
            n = 1 + int'($urandom % 3);
            opt = {7'd0, br, 7'd0, ro, 7'd0, ri, 2'd0, 6'(w)};
            wr(ch, O_POLY, p);
            wr(ch, O_FIN, x);
            wr(ch, O_OPT, opt);
            wr(ch, O_START, i);
            for (int q = 0; q < n; q++) begin
                words[q] = $urandom;
                for (int b = 0; b < 4; b++)
                    msg[q*4+b] = br ? words[q][8*(3-b) +: 8] : words[q][8*b +: 8];
                wr(ch, O_DATA, words[q]);
            end
            if (it < 4) rd_check("R5", "options readback", ch, O_OPT, opt);
            rd_check(br ? "R7" : "R8", $sformatf("hand-set w=%0d ri=%0d ro=%0d br=%0d", w, ri, ro, br),
                     ch, O_RES, ref_crc(p, i, x, w, ri, ro, msg, 4*n));
        end

        // R5: width 0 behaves as 32.
        wr(6, O_POLY, 32'h04C1_1DB7);
        wr(6, O_FIN, 32'h0);
        wr(6, O_OPT, 32'h0);
        wr(6, O_START, 32'h89AB_CDEF);
        wr(6, O_DATA, 32'hCAFE_F00D);
        for (int b = 0; b < 4; b++) msg[b] = 8'(32'hCAFE_F00D >> (8*b));
        rd_check("R5", "width 0 as 32", 6, O_RES,
                 ref_crc(32'h04C1_1DB7, 32'h89AB_CDEF, 0, 32, 0, 0, msg, 4));

        // R6: start write restarts mid-stream.
        wr(6, O_DATA, 32'h1111_2222);
        wr(6, O_START, 32'h89AB_CDEF);
        wr(6, O_DATA, 32'hCAFE_F00D);
        rd_check("R6", "start write reloads", 6, O_RES,
                 ref_crc(32'h04C1_1DB7, 32'h89AB_CDEF, 0, 32, 0, 0, msg, 4));

        // R9: result writes ignored.
        rd(6, O_RES, v);
        wr(6, O_RES, 32'hA5A5_A5A5);
        rd_check("R9", "result write ignored", 6, O_RES, v);

        // R1: reserved word is inert and reads zero.
        wr(6, 'h24, 32'hFFFF_FFFF);
        rd_check("R1", "reserved reads zero", 6, 'h24, 32'h0);
        rd_check("R1", "reserved write inert", 6, O_RES, v);

        // R4: clear with bit 0 low does nothing, with bit 0 high wipes.
        wr(4, O_CODE, 32'd1);
        wr(4, O_DATA, 32'h0BAD_BEEF);
        rd(4, O_RES, v);
        wr(4, O_CLR, 32'hFFFF_FFFE);
        rd_check("R4", "clear bit0 low keeps", 4, O_RES, v);
        wr(4, O_CLR, 32'h1);
        rd_check("R4", "clear reads zero", 4, O_CLR, 32'h0);
        rd_check("R4", "poly cleared", 4, O_POLY, 32'h0);
        rd_check("R4", "code cleared", 4, O_CODE, 32'h0);
        rd_check("R4", "result cleared", 4, O_RES, 32'h0);

        // R10, R7: back-to-back interleaved data writes to two channels.
        wr(2, O_CODE, 32'd1);
        wr(5, O_CODE, 32'd4);
        rd(3, O_RES, v2);
        for (int q = 0; q < 3; q++) begin
            words[q] = $urandom;
            for (int b = 0; b < 4; b++) begin
                msg[q*4+b] = words[q][8*b +: 8];
                m2[q*4+b]  = ~words[q][8*b +: 8];
            end
        end
        @(negedge clk);
        for (int q = 0; q < 3; q++) begin
            addr = wa(2, O_DATA); we = 1'b1; wdata = words[q];
            @(negedge clk);
            addr = wa(5, O_DATA); wdata = ~words[q];
            @(negedge clk);
        end
        we = 1'b0;
        cat(1, p, i, x, w, rf, chk);
        rd_check("R10", "interleaved ch2", 2, O_RES, ref_crc(p, i, x, w, rf, rf, msg, 12));
        cat(4, p, i, x, w, rf, chk);
        rd_check("R10", "interleaved ch5", 5, O_RES, ref_crc(p, i, x, w, rf, rf, m2, 12));
        rd_check("R10", "bystander ch3", 3, O_RES, v2);

        finish_run();
    end

endmodule